// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Register Block

This block holds the message-signalled interrupt capability of one device function inside its configuration space. Software reaches it through a DWORD-wide configuration port with per-byte enables. The port addresses whole DWORDs, and the capability begins at a DWORD index fixed by a parameter. Other parameters select the supported number of vectors (a power of two from 1 to 32), a 32-bit or 64-bit message address, and per-vector masking. Those choices also set the register layout and the length of the capability.

The block filters every configuration write through per-bit write masks. If software enables the function while asking for more vectors than it supports, the block clamps the request. Pending bits that lie beyond the enabled vector count are discarded after each write made while the function is enabled. The legacy INTx request is gated off whenever the function is enabled. Control, address, data, mask and pending values go straight to a message dispatcher. The dispatcher sets and clears pending bits with strobes, and a one-cycle flush pulse tells it when to re-examine the pending vectors.

Top module: `msi_cap_regs`

## Requirements
- R1: A synchronous reset clears the enable bit, the enabled-vector field, both address words, the data word, and the mask and pending bits. The read-only capability bits are kept.
- R2: The control word occupies bytes 2-3 of capability DWORD 0, and bytes 0-1 read as zero. Its bit fields are: bit 0 enable; bits [3:1] log2 of the supported vector count; bits [6:4] log2 of the enabled vector count; bit 7 set for 64-bit addressing; bit 8 set for per-vector masking. Only bit 0 and bits [6:4] accept writes, both through byte enable 2. A read returns its value in the cycle after the read strobe.
- R3: The address low word is at DWORD 1, and its bits [1:0] always read as zero. The address high word is at DWORD 2 and exists only with 64-bit addressing. Without it, the exported upper address half is zero.
- R4: The 16-bit data word sits in the low half of DWORD 2 (32-bit layout) or DWORD 3 (64-bit layout). The upper half reads as zero.
- R5: With masking, the mask register follows the data DWORD. Only bits 0 to N-1 are stored, and higher bits read as zero and ignore writes. Every writable byte of every register changes only when its byte enable is set.
- R6: A write that leaves the enable bit set with an enabled-vector field above the supported value stores the supported value instead. While disabled, the field is stored as written.
- R7: Any write that touches the capability and leaves it enabled clears pending bits at or above the enabled vector count. It also raises `flush_o` for the following cycle. Writes that leave it disabled do neither.
- R8: With masking, the pending register follows the mask DWORD. It ignores configuration writes. A clear strobe bit drops its pending bit and a set strobe bit raises it, and set wins when both are given.
- R9: While the enable bit is set, `intx_req_o` is low. Otherwise it follows `intx_req_i`.
- R10: Reads of DWORDs outside the capability length return zero. Writes there change nothing and raise no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | CFG_AW | Configuration DWORD index |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data, valid the cycle after `cfg_rd` |
| pend_set | input | NVEC | Dispatcher pending-set strobes |
| pend_clr | input | NVEC | Dispatcher pending-clear strobes |
| intx_req_i | input | 1 | Legacy interrupt request from the function |
| intx_req_o | output | 1 | Gated legacy interrupt request |
| msi_en | output | 1 | Enable bit |
| msi_mme | output | 3 | log2 of the enabled vector count |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | NVEC | Per-vector mask bits |
| msi_pend | output | NVEC | Per-vector pending bits |
| flush_o | output | 1 | One-cycle pulse after a write made while enabled |

## Verification
The assertions assume that reads and writes never coincide with reset. They also assume the dispatcher never raises a pending-set strobe for a vector at or above the enabled count during a write cycle, since the purge would race that strobe. The stimulus keeps to these limits: it issues one configuration access at a time, drives strobes only in cycles with no write, and holds reset apart from any access. Both the 64-bit masked layout and the 32-bit unmasked single-vector layout are exercised on one shared configuration bus.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CTRL,
    RSEL_ALO,
    RSEL_AHI,
    RSEL_DATA,
    RSEL_MASK,
    RSEL_PEND
  } rsel_e;

  // capability length in bytes for each layout
  function automatic int unsigned cap_len_bytes(bit a64, bit pvm);
    if (pvm) return a64 ? 24 : 20;
    return a64 ? 14 : 10;
  endfunction

  function automatic int unsigned cap_len_dw(bit a64, bit pvm);
    return (cap_len_bytes(a64, pvm) + 3) / 4;
  endfunction

  function automatic logic [31:0] be_expand(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int CFG_AW       = 6,
  parameter int CAP_BASE_DW  = 20,
  parameter bit ADDR64       = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1
) (
  input  logic [CFG_AW-1:0] dw_addr,
  input  logic [3:0]        be,
  output rsel_e             sel,
  output logic              touch
);
  localparam int LEN_B    = cap_len_bytes(ADDR64, PER_VEC_MASK);
  localparam int LEN_DW   = cap_len_dw(ADDR64, PER_VEC_MASK);
  localparam int OFF_DATA = ADDR64 ? 3 : 2;
  localparam logic [3:0] LAST_BE = (LEN_B % 4 == 0) ? 4'hF : 4'h3;
  localparam logic [CFG_AW-1:0] BASE_V = CFG_AW'(CAP_BASE_DW);
  localparam logic [CFG_AW-1:0] LEN_V  = CFG_AW'(LEN_DW);
  localparam logic [CFG_AW-1:0] LAST_V = CFG_AW'(LEN_DW - 1);
  localparam logic [CFG_AW-1:0] DATA_V = CFG_AW'(OFF_DATA);
  localparam logic [CFG_AW-1:0] MASK_V = CFG_AW'(OFF_DATA + 1);
  localparam logic [CFG_AW-1:0] PEND_V = CFG_AW'(OFF_DATA + 2);

  logic [CFG_AW-1:0] off;
  logic              in_range;
  logic [3:0]        valid_be;

  always_comb begin
    off      = dw_addr - BASE_V;
    in_range = (dw_addr >= BASE_V) && (off < LEN_V);
    valid_be = (off == LAST_V) ? LAST_BE : 4'hF;
    touch    = in_range && (|(be & valid_be));
    sel      = RSEL_NONE;
    if (in_range) begin
      if (off == '0)                          sel = RSEL_CTRL;
      else if (off == CFG_AW'(1))             sel = RSEL_ALO;
      else if (ADDR64 && off == CFG_AW'(2))   sel = RSEL_AHI;
      else if (off == DATA_V)                 sel = RSEL_DATA;
      else if (PER_VEC_MASK && off == MASK_V) sel = RSEL_MASK;
      else if (PER_VEC_MASK && off == PEND_V) sel = RSEL_PEND;
    end
  end
endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl #(
  parameter int LOG2_VEC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic       wr_ctrl,
  input  logic [7:0] wbyte,
  output logic       en_o,
  output logic [2:0] mme_o,
  output logic       flush_o,
  output logic       purge_o,
  output logic [2:0] purge_mme_o
);
  localparam logic [2:0] CAP = 3'(LOG2_VEC);

  logic       en_w;
  logic [2:0] mme_w;
  logic [2:0] mme_n;

  always_comb begin
    en_w  = wr_ctrl ? wbyte[0]   : en_o;
    mme_w = wr_ctrl ? wbyte[6:4] : mme_o;
    mme_n = (wr_hit && en_w && (mme_w > CAP)) ? CAP : mme_w;
    purge_o     = wr_hit && en_w;
    purge_mme_o = mme_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= 1'b0;
      mme_o   <= '0;
      flush_o <= 1'b0;
    end else begin
      flush_o <= wr_hit && en_w;
      if (wr_hit) begin
        en_o  <= en_w;
        mme_o <= mme_n;
      end
    end
  end
endmodule

// File: rtl/msi_cap_vecbits.sv
module msi_cap_vecbits
  import msi_cap_pkg::*;
#(
  parameter int NVEC         = 8,
  parameter bit PER_VEC_MASK = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_mask,
  input  logic [3:0]      be,
  input  logic [31:0]     wdata,
  input  logic [NVEC-1:0] pend_set,
  input  logic [NVEC-1:0] pend_clr,
  input  logic            purge,
  input  logic [2:0]      purge_mme,
  output logic [NVEC-1:0] mask_o,
  output logic [NVEC-1:0] pend_o
);
  generate
    if (PER_VEC_MASK) begin : g_vec
      logic [31:0]     mask_ext;
      logic [31:0]     mask_new;
      logic [NVEC-1:0] keep;
      logic [NVEC-1:0] pend_n;

      always_comb begin
        mask_ext = '0;
        mask_ext[NVEC-1:0] = mask_o;
        mask_new = (mask_ext & ~be_expand(be)) | (wdata & be_expand(be));
        for (int i = 0; i < NVEC; i++) begin
          keep[i] = (32'(i) < (32'd1 << purge_mme));
        end
        pend_n = (pend_o & ~pend_clr) | pend_set;
        if (purge) pend_n = pend_n & keep;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          mask_o <= '0;
          pend_o <= '0;
        end else begin
          if (wr_mask) mask_o <= mask_new[NVEC-1:0];
          pend_o <= pend_n;
        end
      end
    end else begin : g_novec
      assign mask_o = '0;
      assign pend_o = '0;
    end
  endgenerate
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int CFG_AW       = 6,
  parameter int CAP_BASE_DW  = 20,
  parameter int LOG2_VEC     = 3,
  parameter bit ADDR64       = 1'b1,
  parameter bit PER_VEC_MASK = 1'b1,
  localparam int NVEC        = 1 << LOG2_VEC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_dw_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [NVEC-1:0]   pend_set,
  input  logic [NVEC-1:0]   pend_clr,
  input  logic              intx_req_i,
  output logic              intx_req_o,
  output logic              msi_en,
  output logic [2:0]        msi_mme,
  output logic [63:0]       msi_addr,
  output logic [15:0]       msi_data,
  output logic [NVEC-1:0]   msi_mask,
  output logic [NVEC-1:0]   msi_pend,
  output logic              flush_o
);
  rsel_e       sel;
  logic        touch;
  logic        wr_hit;
  logic        wr_ctrl;
  logic        purge;
  logic [2:0]  purge_mme;
  logic [31:0] bem;
  logic [29:0] addr_lo_q;
  logic [31:0] addr_hi_q;
  logic [15:0] data_q;
  logic [31:0] alo_new;
  logic [31:0] data_new;
  logic [15:0] ctrl16;
  logic [31:0] rd_val;

  msi_cap_decode #(
    .CFG_AW(CFG_AW), .CAP_BASE_DW(CAP_BASE_DW),
    .ADDR64(ADDR64), .PER_VEC_MASK(PER_VEC_MASK)
  ) u_dec (
    .dw_addr(cfg_dw_addr), .be(cfg_be), .sel(sel), .touch(touch)
  );

  assign wr_hit  = cfg_wr && touch;
  assign wr_ctrl = cfg_wr && (sel == RSEL_CTRL) && cfg_be[2];
  assign bem     = be_expand(cfg_be);

  msi_cap_ctrl #(.LOG2_VEC(LOG2_VEC)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_ctrl(wr_ctrl),
    .wbyte(cfg_wdata[23:16]), .en_o(msi_en), .mme_o(msi_mme),
    .flush_o(flush_o), .purge_o(purge), .purge_mme_o(purge_mme)
  );

  msi_cap_vecbits #(.NVEC(NVEC), .PER_VEC_MASK(PER_VEC_MASK)) u_vec (
    .clk(clk), .rst(rst),
    .wr_mask(cfg_wr && (sel == RSEL_MASK)),
    .be(cfg_be), .wdata(cfg_wdata),
    .pend_set(pend_set), .pend_clr(pend_clr),
    .purge(purge), .purge_mme(purge_mme),
    .mask_o(msi_mask), .pend_o(msi_pend)
  );

  // address low and data words
  always_comb begin
    alo_new  = ({addr_lo_q, 2'b00} & ~bem) | (cfg_wdata & bem);
    data_new = ({16'h0, data_q} & ~bem) | (cfg_wdata & bem);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo_q <= '0;
      data_q    <= '0;
    end else if (cfg_wr) begin
      if (sel == RSEL_ALO)  addr_lo_q <= alo_new[31:2];
      if (sel == RSEL_DATA) data_q    <= data_new[15:0];
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk) begin
        if (rst) addr_hi_q <= '0;
        else if (cfg_wr && sel == RSEL_AHI)
          addr_hi_q <= (addr_hi_q & ~bem) | (cfg_wdata & bem);
      end
    end else begin : g_nohi
      assign addr_hi_q = '0;
    end
  endgenerate

  assign msi_addr   = {addr_hi_q, addr_lo_q, 2'b00};
  assign msi_data   = data_q;
  assign intx_req_o = intx_req_i && !msi_en;

  always_comb begin
    ctrl16 = {7'd0, PER_VEC_MASK, ADDR64, msi_mme, 3'(LOG2_VEC), msi_en};
    rd_val = '0;
    case (sel)
      RSEL_CTRL: rd_val = {ctrl16, 16'h0};
      RSEL_ALO:  rd_val = {addr_lo_q, 2'b00};
      RSEL_AHI:  rd_val = addr_hi_q;
      RSEL_DATA: rd_val = {16'h0, data_q};
      RSEL_MASK: rd_val[NVEC-1:0] = msi_mask;
      RSEL_PEND: rd_val[NVEC-1:0] = msi_pend;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= cfg_rd ? rd_val : 32'h0;
  end
endmodule

// File: rtl/msi_cap_regs_chk.sv
module msi_cap_regs_chk #(
  parameter int LOG2_VEC = 3,
  parameter int NVEC     = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            msi_en,
  input logic [2:0]      msi_mme,
  input logic [63:0]     msi_addr,
  input logic [15:0]     msi_data,
  input logic [NVEC-1:0] msi_mask,
  input logic [NVEC-1:0] msi_pend,
  input logic [NVEC-1:0] pend_set,
  input logic [NVEC-1:0] pend_clr,
  input logic            flush_o,
  input logic            intx_req_o
);
  logic [NVEC-1:0] keep;
  always_comb begin
    for (int i = 0; i < NVEC; i++) keep[i] = (32'(i) < (32'd1 << msi_mme));
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!msi_en && msi_mme == 3'd0 && msi_addr == 64'd0 &&
             msi_data == 16'd0 && msi_mask == '0 && msi_pend == '0));

  p_clamped_r6: assert property (@(posedge clk) disable iff (rst)
    msi_en |-> (msi_mme <= 3'(LOG2_VEC)));

  p_purged_r7: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> ((msi_pend & ~keep) == '0));

  p_pend_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (pend_set == '0 && pend_clr == '0) |=> ($stable(msi_pend) || flush_o));

  p_intx_gated_r9: assert property (@(posedge clk) disable iff (rst)
    msi_en |-> !intx_req_o);
endmodule

bind msi_cap_regs msi_cap_regs_chk #(.LOG2_VEC(LOG2_VEC), .NVEC(NVEC)) u_chk (
  .clk(clk), .rst(rst), .msi_en(msi_en), .msi_mme(msi_mme),
  .msi_addr(msi_addr), .msi_data(msi_data), .msi_mask(msi_mask),
  .msi_pend(msi_pend), .pend_set(pend_set), .pend_clr(pend_clr),
  .flush_o(flush_o), .intx_req_o(intx_req_o)
);

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
  localparam int AW   = 6;
  localparam int BASE = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [AW-1:0]  cfg_dw_addr = '0;
  logic [3:0]     cfg_be = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [31:0]    rdA, rdB;
  logic [7:0]     pend_set = '0, pend_clr = '0;
  logic           intx_i = 1'b0, intx_o, intx_o2;
  logic           en, flush, en2, flush2;
  logic [2:0]     mme, mme2;
  logic [63:0]    addr, addr2;
  logic [15:0]    data, data2;
  logic [7:0]     mask, pend;
  logic [0:0]     mask2, pend2;

  msi_cap_regs #(.CFG_AW(AW), .CAP_BASE_DW(BASE), .LOG2_VEC(3),
                 .ADDR64(1'b1), .PER_VEC_MASK(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdA), .pend_set(pend_set), .pend_clr(pend_clr),
    .intx_req_i(intx_i), .intx_req_o(intx_o), .msi_en(en), .msi_mme(mme),
    .msi_addr(addr), .msi_data(data), .msi_mask(mask), .msi_pend(pend),
    .flush_o(flush));

  msi_cap_regs #(.CFG_AW(AW), .CAP_BASE_DW(BASE), .LOG2_VEC(0),
                 .ADDR64(1'b0), .PER_VEC_MASK(1'b0)) u_dut32 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdB), .pend_set(1'b0), .pend_clr(1'b0),
    .intx_req_i(intx_i), .intx_req_o(intx_o2), .msi_en(en2), .msi_mme(mme2),
    .msi_addr(addr2), .msi_data(data2), .msi_mask(mask2), .msi_pend(pend2),
    .flush_o(flush2));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw_addr = AW'(dw); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input int dw);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw_addr = AW'(dw);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    pend_set = '0; pend_clr = '0;
  endtask

  typedef struct packed {
    logic        do_wr;
    logic [2:0]  woff;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [2:0]  roff;
    logic [31:0] exp;
    logic [7:0]  req;
  } row_t;

  // 64-bit masked layout: 0 ctrl, 1 addr lo, 2 addr hi, 3 data, 4 mask, 5 pending
  localparam row_t TBL [11] = '{
    '{1'b0, 3'd0, 4'h0, 32'h0,        3'd0, 32'h0186_0000, 8'd2},  // R2 reset view
    '{1'b1, 3'd1, 4'hF, 32'hDEADBEEF, 3'd1, 32'hDEADBEEC, 8'd3},  // R3
    '{1'b1, 3'd2, 4'hF, 32'h12345678, 3'd2, 32'h12345678, 8'd3},  // R3
    '{1'b1, 3'd3, 4'hF, 32'hABCD9876, 3'd3, 32'h0000_9876, 8'd4},  // R4
    '{1'b1, 3'd4, 4'hF, 32'hFFFFFFFF, 3'd4, 32'h0000_00FF, 8'd5},  // R5
    '{1'b1, 3'd4, 4'h1, 32'h0000005A, 3'd4, 32'h0000_005A, 8'd5},  // R5
    '{1'b1, 3'd0, 4'h8, 32'hFFFFFFFF, 3'd0, 32'h0186_0000, 8'd2},  // R2 read-only byte
    '{1'b1, 3'd0, 4'h4, 32'h0050_0000, 3'd0, 32'h01D6_0000, 8'd6}, // R6 no clamp disabled
    '{1'b1, 3'd5, 4'hF, 32'hFFFFFFFF, 3'd5, 32'h0,        8'd8},  // R8 write ignored
    '{1'b1, 3'd1, 4'h4, 32'h0011_0000, 3'd1, 32'hDE11BEEC, 8'd5}, // R5 byte enable
    '{1'b1, 3'd6, 4'hF, 32'hFFFFFFFF, 3'd6, 32'h0,        8'd10}  // R10 outside
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset enable", {63'd0, en}, 64'd0);
    chk("R1 reset pending", {56'd0, pend}, 64'd0);

    foreach (TBL[i]) begin
      if (TBL[i].do_wr) begin
        wr(BASE + int'(TBL[i].woff), TBL[i].be, TBL[i].wd);
        chk("R7 no flush while disabled", {63'd0, flush}, 64'd0);
      end
      rd(BASE + int'(TBL[i].roff));
      chk($sformatf("R%0d table row %0d", TBL[i].req, i), {32'd0, rdA}, {32'd0, TBL[i].exp});
    end

    // R8 pending strobes
    strobe(8'hA3, 8'h00);
    rd(BASE + 5);
    chk("R8 pending set", {32'd0, rdA}, 64'h0000_00A3);
    strobe(8'h00, 8'h21);
    chk("R8 pending clear", {56'd0, pend}, 64'h82);
    strobe(8'h01, 8'h01);
    chk("R8 set wins over clear", {56'd0, pend}, 64'h83);
    strobe(8'h00, 8'h01);

    // R6 clamp on enable, R7 flush
    wr(BASE, 4'h4, 32'h0061_0000);
    chk("R7 flush after enabled write", {63'd0, flush}, 64'd1);
    rd(BASE);
    chk("R6 clamp to capable", {32'd0, rdA}, 64'h01B7_0000);
    chk("R6 exported field", {61'd0, mme}, 64'd3);
    chk("R7 no purge at full count", {56'd0, pend}, 64'h82);

    intx_i = 1'b1;
    @(negedge clk);
    chk("R9 intx gated while enabled", {63'd0, intx_o}, 64'd0);

    wr(BASE, 4'h4, 32'h0011_0000);
    rd(BASE + 5);
    chk("R7 purge above two vectors", {32'd0, rdA}, 64'h02);

    strobe(8'h80, 8'h00);
    chk("R8 strobe beyond count kept", {56'd0, pend}, 64'h82);
    wr(BASE + 2, 4'hF, 32'h0);
    chk("R7 flush on any register write", {63'd0, flush}, 64'd1);
    chk("R7 purge on address write", {56'd0, pend}, 64'h02);

    wr(BASE + 6, 4'hF, 32'hFFFF_FFFF);
    chk("R10 outside write no flush", {63'd0, flush}, 64'd0);
    rd(BASE - 1);
    chk("R10 read below base", {32'd0, rdA}, 64'd0);

    wr(BASE, 4'h4, 32'h0010_0000);
    chk("R7 disabling write no flush", {63'd0, flush}, 64'd0);
    chk("R9 intx follows when disabled", {63'd0, intx_o}, 64'd1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(BASE);
    chk("R1 control after reset", {32'd0, rdA}, 64'h0186_0000);
    chk("R1 address after reset", addr, 64'd0);
    chk("R1 data after reset", {48'd0, data}, 64'd0);
    chk("R1 mask after reset", {56'd0, mask}, 64'd0);
    chk("R1 pending after reset", {56'd0, pend}, 64'd0);

    // 32-bit unmasked single-vector instance
    chk("R2 small layout control", {32'd0, rdB}, 64'd0);
    wr(BASE + 2, 4'hF, 32'hFFFF_1234);
    rd(BASE + 2);
    chk("R4 data at dword 2", {32'd0, rdB}, 64'h1234);
    rd(BASE + 3);
    chk("R10 small layout past end", {32'd0, rdB}, 64'd0);
    wr(BASE + 1, 4'hF, 32'h0000_0007);
    chk("R3 no upper address", addr2, 64'h4);
    wr(BASE, 4'h4, 32'h0031_0000);
    rd(BASE);
    chk("R6 clamp to one vector", {32'd0, rdB}, 64'h0001_0000);
    chk("R9 small instance gated", {63'd0, intx_o2}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule